// File: doc/BRIEF.md
# Half-Cycle Companding Code Expander

This block sits right after an ADC that digitizes a companded (compressed) signal. Each ADC sample arrives as a sign bit plus a magnitude code. It also carries the 2-bit gain state that the compressor applied when the sample was taken. The block restores a consistent scale inside each signal half-cycle, and it does this in the digital domain, so no analog expansion stage is needed. A half-cycle is a run of samples with the same sign. Within one half-cycle, the reference is the smallest gain used, which is the gain in force at the peak. Every sample taken at a larger gain is requantized down to that reference scale by a right shift of its magnitude code.

Samples are collected in an internal buffer until their half-cycle closes. A half-cycle closes when the sign changes or when the buffer fills. The block then holds off new input and streams the corrected codes out in arrival order. Both sides use valid/ready handshakes:
- A transfer happens on a rising clock edge where valid and ready are both high.
- `in_ready` is high only while a half-cycle is being collected.
- `out_valid` is high only while a closed half-cycle is being drained.
- While `out_valid` is high and `out_ready` is low, the output code is held steady.

Top module: `xp_expander`

## Requirements
- R1: The gain state is coded 0 for gain 1, 1 for gain 1/2 and 2 for gain 1/4. The value 3 is treated as state 2.
- R2: The reference for a half-cycle is the largest gain state (smallest gain) among its samples.
- R3: Each output magnitude equals the buffered magnitude shifted right, logically, by the reference state minus the sample's own state. The sign bit passes through unchanged.
- R4: A sample whose state equals the reference comes out with its magnitude unchanged.
- R5: For a relative gain of 2, magnitudes 0 and 1 become 0, and magnitudes 2 and 3 become 1.
- R6: For a relative gain of 4, magnitudes 0 to 3 all become 0, and in general the magnitude is divided by 4 with truncation.
- R7: The current half-cycle closes when an accepted sample's sign differs from the previous accepted sample's sign while the buffer is not empty. That sample opens the next half-cycle and does not belong to the one being closed. No corrected code leaves before its half-cycle closes.
- R8: When the buffer reaches DEPTH samples, the half-cycle closes at once without a sign change. The next sample then starts a fresh half-cycle whatever its sign.
- R9: While a closed half-cycle drains, `in_ready` is low. Outputs keep arrival order. Output data are stable while `out_valid` is high and `out_ready` is low.
- R10: A synchronous reset empties the buffer, sets the running reference to state 0, drives `out_valid` low and `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sign | input | 1 | Sign bit of the ADC code |
| in_mag | input | MAG_W | Magnitude part of the ADC code |
| in_state | input | 2 | Compression gain state of the sample |
| out_valid | output | 1 | Corrected sample valid |
| out_ready | input | 1 | Downstream accepts the corrected sample |
| out_sign | output | 1 | Sign bit of the corrected code |
| out_mag | output | MAG_W | Corrected magnitude |

## Verification
The bench targets half-cycles that mix all three gain states, including the illegal code 3. If the reference were taken from the first or last sample instead of the largest state, magnitudes would come out shifted by the wrong amount. It also checks the sign-change sample that closes a half-cycle. A design that folded that sample into the closing group, or dropped it, would emit a wrong code or lose one. A burst of DEPTH same-sign samples checks that the buffer-full close happens without a sign change; a design that missed it would overflow or stall. Random back-pressure on the output shows any drop, duplicate, reorder or change of a held code, and any input taken while draining.

// File: rtl/xp_pkg.sv
package xp_pkg;

  typedef logic [1:0] gstate_t;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_t;

  localparam gstate_t GST_MAX = 2'd2;

  // fold the unused code onto the deepest compression step
  function automatic gstate_t gst_clamp(input gstate_t s);
    return (s > GST_MAX) ? GST_MAX : s;
  endfunction

  function automatic gstate_t gst_deeper(input gstate_t a, input gstate_t b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/xp_fifo.sv
module xp_fifo #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [W-1:0]                   wdata,
  input  logic                           pop,
  output logic [W-1:0]                   rdata,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= ptr_next(wptr);
      if (pop)  rptr <= ptr_next(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    full |-> !(push && !pop));
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);

endmodule

// File: rtl/xp_shift.sv
module xp_shift #(
  parameter int unsigned MAG_W = 7
) (
  input  logic [MAG_W-1:0] mag_in,
  input  logic [1:0]       shift,
  output logic [MAG_W-1:0] mag_out
);
  // one output lane per bit; each picks its source 0, 1 or 2 places up
  for (genvar b = 0; b < MAG_W; b++) begin : g_lane
    always_comb begin
      mag_out[b] = 1'b0;
      case (shift)
        2'd0: mag_out[b] = mag_in[b];
        2'd1: if (b + 1 < MAG_W) mag_out[b] = mag_in[(b + 1) % MAG_W];
        2'd2: if (b + 2 < MAG_W) mag_out[b] = mag_in[(b + 2) % MAG_W];
        default: mag_out[b] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/xp_ctrl.sv
module xp_ctrl
  import xp_pkg::*;
#(
  parameter int unsigned EW    = 10,
  parameter int unsigned DEPTH = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_sign,
  input  gstate_t                     in_state,
  input  logic [EW-1:0]               in_entry,
  input  logic [$clog2(DEPTH+1)-1:0]  fifo_count,
  input  logic                        fifo_empty,
  input  logic                        out_ready,
  output logic                        in_ready,
  output logic                        out_valid,
  output logic                        pop,
  output logic                        push_in,
  output logic                        push_carry,
  output logic [EW-1:0]               carry_entry,
  output gstate_t                     ref_state
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  phase_t  phase;
  gstate_t run_min;
  logic    last_sign;
  logic    carry_vld;

  logic    acc, boundary, fills_up, last_pop;
  gstate_t grown;

  always_comb begin
    in_ready   = (phase == PH_FILL);
    acc        = in_valid && in_ready;
    boundary   = acc && !fifo_empty && (in_sign != last_sign);
    grown      = gst_deeper(run_min, in_state);
    push_in    = acc && !boundary;
    fills_up   = push_in && (fifo_count == CNT_W'(DEPTH-1));
    out_valid  = (phase == PH_DRAIN) && !fifo_empty;
    pop        = out_valid && out_ready;
    last_pop   = pop && (fifo_count == CNT_W'(1));
    push_carry = last_pop && carry_vld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_FILL;
      run_min     <= '0;
      ref_state   <= '0;
      last_sign   <= 1'b0;
      carry_vld   <= 1'b0;
      carry_entry <= '0;
    end else begin
      if (acc) last_sign <= in_sign;
      if (phase == PH_FILL) begin
        if (boundary) begin
          ref_state   <= run_min;
          run_min     <= in_state;
          carry_entry <= in_entry;
          carry_vld   <= 1'b1;
          phase       <= PH_DRAIN;
        end else if (fills_up) begin
          ref_state <= grown;
          run_min   <= '0;
          phase     <= PH_DRAIN;
        end else if (acc) begin
          run_min <= grown;
        end
      end else if (last_pop) begin
        phase     <= PH_FILL;
        carry_vld <= 1'b0;
      end
    end
  end

  p_push_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(push_in && push_carry));
  p_ref_legal_r1: assert property (@(posedge clk) disable iff (rst)
    ref_state <= GST_MAX);
  p_ref_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !last_pop) |=> $stable(ref_state));
  p_reset_idle_r10: assert property (@(posedge clk)
    $past(rst) |-> (in_ready && !out_valid));

endmodule

// File: rtl/xp_expander.sv
module xp_expander
  import xp_pkg::*;
#(
  parameter int unsigned MAG_W = 7,
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sign,
  input  logic [MAG_W-1:0] in_mag,
  input  logic [1:0]       in_state,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sign,
  output logic [MAG_W-1:0] out_mag
);
  localparam int unsigned EW    = MAG_W + 3;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  gstate_t              st_in, head_st, ref_state;
  logic [EW-1:0]        in_entry, carry_entry, wdata, head;
  logic [CNT_W-1:0]     fifo_count;
  logic                 fifo_full, fifo_empty;
  logic                 pop, push_in, push_carry;
  logic [1:0]           rel_shift;
  logic [MAG_W-1:0]     head_mag;

  assign st_in    = gst_clamp(in_state);
  assign in_entry = {in_sign, st_in, in_mag};
  assign wdata    = push_carry ? carry_entry : in_entry;

  xp_ctrl #(.EW(EW), .DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sign    (in_sign),
    .in_state   (st_in),
    .in_entry   (in_entry),
    .fifo_count (fifo_count),
    .fifo_empty (fifo_empty),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .pop        (pop),
    .push_in    (push_in),
    .push_carry (push_carry),
    .carry_entry(carry_entry),
    .ref_state  (ref_state)
  );

  xp_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .push (push_in || push_carry),
    .wdata(wdata),
    .pop  (pop),
    .rdata(head),
    .count(fifo_count),
    .full (fifo_full),
    .empty(fifo_empty)
  );

  assign head_st   = head[MAG_W +: 2];
  assign head_mag  = head[MAG_W-1:0];
  assign rel_shift = ref_state - head_st;
  assign out_sign  = head[EW-1];

  xp_shift #(.MAG_W(MAG_W)) u_shift (
    .mag_in (head_mag),
    .shift  (rel_shift),
    .mag_out(out_mag)
  );

  p_ref_covers_head_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ref_state >= head_st));
  p_out_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sign) && $stable(out_mag)));
  p_no_take_while_drain_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  p_full_drains_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !in_ready);

endmodule

// File: tb/xp_expander_tb_top.sv
module xp_expander_tb_top;
  localparam int MAG_W = 7;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0, in_sign = 1'b0, out_ready = 1'b0;
  logic [MAG_W-1:0] in_mag = '0;
  logic [1:0]       in_state = '0;
  logic             in_ready, out_valid, out_sign;
  logic [MAG_W-1:0] out_mag;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  xp_expander #(.MAG_W(MAG_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_mag(in_mag), .in_state(in_state),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_mag(out_mag)
  );

  // model state: current half-cycle and expected outputs {shift, sign, mag}
  logic [MAG_W+2:0] cur_q[$];
  logic [MAG_W+2:0] exp_q[$];
  int   m_min = 0;
  logic m_last = 1'b0;

  logic             s_ov, s_ir, s_os, p_hold;
  logic [MAG_W-1:0] s_om, p_mag;
  logic             p_sign;

  function automatic int clamp_st(input int s);
    return (s == 3) ? 2 : s;
  endfunction

  function automatic string tag_of(input int sh);
    if (sh == 0) return "R4";
    if (sh == 1) return "R5";
    return "R6";
  endfunction

  task automatic close_half(input int ref_st);
    foreach (cur_q[i]) begin
      int own = int'(cur_q[i][MAG_W+1:MAG_W]);
      int sh  = ref_st - own;
      logic [MAG_W-1:0] m = cur_q[i][MAG_W-1:0] >> sh;
      exp_q.push_back({2'(sh), cur_q[i][MAG_W+2], m});
    end
    cur_q.delete();
  endtask

  task automatic model_accept(input logic sg, input logic [MAG_W-1:0] mg, input int st);
    int cs = clamp_st(st);
    if (cur_q.size() != 0 && sg != m_last) begin
      close_half(m_min);                       // R7 sign change closes
      cur_q.push_back({sg, 2'(cs), mg});
      m_min = cs;
    end else begin
      cur_q.push_back({sg, 2'(cs), mg});
      if (cs > m_min) m_min = cs;              // R2 deepest state is reference
      if (cur_q.size() == DEPTH) begin         // R8 full buffer closes
        close_half(m_min);
        m_min = 0;
      end
    end
    m_last = sg;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cycle(input logic v, input logic sg, input logic [MAG_W-1:0] mg,
                       input int st, input logic rdy);
    @(negedge clk);
    in_valid = v; in_sign = sg; in_mag = mg; in_state = 2'(st); out_ready = rdy;
    #9;
    s_ov = out_valid; s_ir = in_ready; s_os = out_sign; s_om = out_mag;
    if (p_hold) begin
      check(s_ov && s_os == p_sign && s_om == p_mag, "R9 hold", int'(s_om), int'(p_mag));
    end
    if (s_ov) check(!s_ir, "R9 ready low while draining", int'(s_ir), 0);
    if (v && s_ir) model_accept(sg, mg, st);
    if (s_ov && rdy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 early output", int'(s_om), -1);
      end else begin
        logic [MAG_W+2:0] e = exp_q.pop_front();
        string t = tag_of(int'(e[MAG_W+2:MAG_W+1]));
        check(s_os == e[MAG_W], {t, " R3 sign"}, int'(s_os), int'(e[MAG_W]));
        check(s_om == e[MAG_W-1:0], {t, " R3 magnitude"}, int'(s_om), int'(e[MAG_W-1:0]));
      end
    end
    p_hold = s_ov && !rdy; p_sign = s_os; p_mag = s_om;
    @(posedge clk);
  endtask

  task automatic drain_all();
    for (int k = 0; k < 40 && exp_q.size() != 0; k++) cycle(1'b0, 1'b0, '0, 0, 1'b1);
  endtask

  initial begin
    p_hold = 1'b0; p_sign = 1'b0; p_mag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #9;
    check(!out_valid, "R10 out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R10 in_ready after reset", int'(in_ready), 1);
    @(posedge clk);

    // R5 example: reference state 1
    cycle(1, 0, 3, 0, 1); cycle(1, 0, 2, 0, 1); cycle(1, 0, 1, 1, 1); cycle(1, 0, 0, 0, 1);
    cycle(1, 1, 2, 0, 1);   // sign change closes (R7)
    drain_all();
    // R6: reference state 2 reached inside the half-cycle
    cycle(1, 1, 3, 0, 1); cycle(1, 1, 1, 0, 1); cycle(1, 1, 100, 2, 1); cycle(1, 1, 37, 0, 1);
    cycle(1, 0, 5, 1, 1);
    drain_all();
    // R1: code 3 acts as state 2
    cycle(1, 0, 9, 3, 1); cycle(1, 0, 9, 1, 0); cycle(1, 1, 9, 0, 0);
    drain_all();
    // R8: full buffer closes without a sign change
    for (int i = 0; i < DEPTH; i++) cycle(1, 1, 7'(20 + i), i % 2, 0);
    cycle(0, 1, 0, 0, 0);
    check(s_ov && !s_ir, "R8 full close", int'(s_ov), 1);
    drain_all();
    cycle(1, 0, 44, 0, 1);  // fresh half-cycle after the forced close
    cycle(1, 0, 45, 2, 1);
    cycle(1, 1, 46, 0, 1);
    drain_all();

    // random traffic
    begin
      logic sg = 1'b0;
      void'($urandom(32'd1234));
      for (int n = 0; n < 4000; n++) begin
        logic v, r;
        if ($urandom_range(5) == 0) sg = ~sg;
        v = ($urandom_range(9) < 7);
        r = ($urandom_range(9) < 6);
        cycle(v, sg, 7'($urandom), int'($urandom_range(3)), r);
      end
      for (int k = 0; k < 50 && !s_ir; k++) cycle(1'b0, sg, '0, 0, 1'b1);
      cycle(1, ~sg, 0, 0, 1);
      drain_all();
    end
    check(exp_q.size() == 0, "R9 all closed samples delivered", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule